// File: doc/BRIEF.md
# Dual-Clock Split-Round ASCON Permutation

This block runs the ASCON permutation on a 320-bit state. Each round is split into two halves that sit in different clock domains. On the fast clock, the round constant is added and the bitsliced 5-bit S-box is applied across all 64 columns. On the slow clock, the linear diffusion layer is applied. Two asynchronous FIFOs with Gray-coded pointers connect the halves, one in each direction. A state goes around this ring once per round and leaves when its last round is done.

A caller presents a state and a round count on a valid/ready port in the fast domain. The permuted state comes back on a valid/ready port in the slow domain, and that port honours back-pressure. An admission counter limits the number of states in the ring. This keeps the two FIFOs from filling at the same time, so they cannot deadlock. Each clock has its own active-low reset, which asserts asynchronously and releases synchronously inside the block.

Top module: `ascon_split_perm`

## Requirements
- R1: Word x0 is carried in bits 319:256 and x4 in bits 63:0. With a round count of 12, the output equals twelve rounds of the permutation.
  - Each round first XORs the constant {(15-i),i} (8 bits, zero-extended) into x2 for round index i.
  - It then applies the standard bitsliced ASCON S-box to every column.
  - Finally it sets each word to itself XOR two right rotations of itself: x0 by 19/28, x1 by 61/39, x2 by 1/6, x3 by 10/17, x4 by 7/41.
- R2: A round count n from 1 to 12 applies only the last n rounds, with round indices 12-n through 11.
- R3: A round count of 0, or any value above 12, is processed as 12 rounds.
- R4: States that carry the same round count leave in the order they were accepted.
- R5: While outValid is high and outReady is low, outValid stays high and outState does not change.
- R6: At most DEPTH states (4 by default) are accepted but not yet delivered. After that, inReady stays low until an output handshake frees a slot. Neither FIFO is ever written while it is full.
- R7: After both resets are released, outValid is low and inReady is high.
- R8: Results are correct whether the slow clock is slower than, equal to, or faster than the fast clock.
- R9: Every accepted state is delivered exactly once. No FIFO is read while it is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkFast | input | 1 | Clock for the constant and substitution half |
| rstFastN | input | 1 | Active-low reset for the fast domain |
| clkSlow | input | 1 | Clock for the diffusion half and the output port |
| rstSlowN | input | 1 | Active-low reset for the slow domain |
| inValid | input | 1 | An input state is offered |
| inReady | output | 1 | The block accepts the offered state at this fast edge |
| inState | input | 320 | Input state, x0 in the top word |
| inRounds | input | 4 | Number of rounds to apply (0 or above 12 means 12) |
| outValid | output | 1 | A permuted state is available |
| outReady | input | 1 | Consumer takes the state at this slow edge |
| outState | output | 320 | Permuted state, x0 in the top word |

## Verification
The permutation is exercised with several inputs: a zero state, an all-ones state, and several distinct word patterns. These are run with 12, 11, 6 and 1 rounds, which separates errors in the constant schedule from errors in the S-box and the rotations. Out-of-range counts are compared against the 12-round result. Bursts of states are checked for arrival order and count, and each burst is repeated at slow-to-fast period ratios of 2, 3, 1 and 0.6. These ratios stress the pointer synchronizers in both directions. A long stall on the output shows the admission limit and the hold behaviour, and then the stalled burst must drain intact.

// File: rtl/ascon_split_pkg.sv
package ascon_split_pkg;
  localparam int WORD_W    = 64;
  localparam int STATE_W   = 5 * WORD_W;
  localparam int RIDX_W    = 4;
  localparam int MAX_ROUND = 12;
  localparam logic [RIDX_W-1:0] LAST_IDX = RIDX_W'(MAX_ROUND - 1);

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [STATE_W-1:0] state_t;

  typedef struct packed {
    state_t            st;
    logic [RIDX_W-1:0] idx;
  } entry_t;

  localparam int ENTRY_W = $bits(entry_t);

  // Strobes from the control of each half to its datapath.
  typedef struct packed {
    logic takeRet;
    logic takeIn;
  } fastStb_t;

  typedef struct packed {
    logic toOut;
    logic toRet;
  } slowStb_t;

  function automatic word_t rotr(input word_t w, input int n);
    return (w >> n) | (w << (WORD_W - n));
  endfunction

  function automatic word_t roundConst(input logic [RIDX_W-1:0] idx);
    return word_t'({4'hF - idx, idx});
  endfunction

  function automatic state_t subLayer(input state_t s, input logic [RIDX_W-1:0] idx);
    word_t a0, a1, a2, a3, a4, t0, t1, t2, t3, t4;
    a0 = s[319:256]; a1 = s[255:192]; a2 = s[191:128]; a3 = s[127:64]; a4 = s[63:0];
    a2 = a2 ^ roundConst(idx);
    a0 = a0 ^ a4; a4 = a4 ^ a3; a2 = a2 ^ a1;
    t0 = ~a0 & a1; t1 = ~a1 & a2; t2 = ~a2 & a3; t3 = ~a3 & a4; t4 = ~a4 & a0;
    a0 = a0 ^ t1; a1 = a1 ^ t2; a2 = a2 ^ t3; a3 = a3 ^ t4; a4 = a4 ^ t0;
    a1 = a1 ^ a0; a0 = a0 ^ a4; a3 = a3 ^ a2; a2 = ~a2;
    return {a0, a1, a2, a3, a4};
  endfunction

  function automatic state_t diffLayer(input state_t s);
    word_t a0, a1, a2, a3, a4;
    a0 = s[319:256]; a1 = s[255:192]; a2 = s[191:128]; a3 = s[127:64]; a4 = s[63:0];
    a0 = a0 ^ rotr(a0, 19) ^ rotr(a0, 28);
    a1 = a1 ^ rotr(a1, 61) ^ rotr(a1, 39);
    a2 = a2 ^ rotr(a2, 1)  ^ rotr(a2, 6);
    a3 = a3 ^ rotr(a3, 10) ^ rotr(a3, 17);
    a4 = a4 ^ rotr(a4, 7)  ^ rotr(a4, 41);
    return {a0, a1, a2, a3, a4};
  endfunction
endpackage

// File: rtl/ascon_rst_sync.sv
module ascon_rst_sync (
  input  logic clk,
  input  logic arstN,
  output logic srstN
);
  logic stage1;
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      stage1 <= 1'b0;
      srstN  <= 1'b0;
    end else begin
      stage1 <= 1'b1;
      srstN  <= stage1;
    end
  end
endmodule

// File: rtl/ascon_xfifo.sv
module ascon_xfifo #(
  parameter int WIDTH  = 324,
  parameter int ADDR_W = 2   // at least 2
) (
  input  logic             wClk,
  input  logic             wRstN,
  input  logic             wEn,
  input  logic [WIDTH-1:0] wData,
  output logic             wFull,
  input  logic             rClk,
  input  logic             rRstN,
  input  logic             rEn,
  output logic [WIDTH-1:0] rData,
  output logic             rEmpty
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] FULL_FLIP = {2'b11, {(PTR_W-2){1'b0}}};

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wBin, wGray, rBin, rGray;
  logic [PTR_W-1:0] rGrayS1, rGrayS2, wGrayS1, wGrayS2;
  logic [PTR_W-1:0] wBinNext, rBinNext;

  assign wFull    = (wGray == (rGrayS2 ^ FULL_FLIP));
  assign rEmpty   = (rGray == wGrayS2);
  assign wBinNext = wBin + PTR_W'(1);
  assign rBinNext = rBin + PTR_W'(1);
  assign rData    = mem[rBin[ADDR_W-1:0]];

  always_ff @(posedge wClk) begin
    if (wEn && !wFull) mem[wBin[ADDR_W-1:0]] <= wData;
  end

  always_ff @(posedge wClk or negedge wRstN) begin
    if (!wRstN) begin
      wBin <= '0; wGray <= '0; rGrayS1 <= '0; rGrayS2 <= '0;
    end else begin
      rGrayS1 <= rGray;
      rGrayS2 <= rGrayS1;
      if (wEn && !wFull) begin
        wBin  <= wBinNext;
        wGray <= wBinNext ^ (wBinNext >> 1);
      end
    end
  end

  always_ff @(posedge rClk or negedge rRstN) begin
    if (!rRstN) begin
      rBin <= '0; rGray <= '0; wGrayS1 <= '0; wGrayS2 <= '0;
    end else begin
      wGrayS1 <= wGray;
      wGrayS2 <= wGrayS1;
      if (rEn && !rEmpty) begin
        rBin  <= rBinNext;
        rGray <= rBinNext ^ (rBinNext >> 1);
      end
    end
  end
endmodule

// File: rtl/ascon_fast_stage.sv
module ascon_fast_stage
  import ascon_split_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  state_t             inState,
  input  logic [3:0]         inRounds,
  input  logic               retEmpty,
  input  logic [ENTRY_W-1:0] retData,
  output logic               retPop,
  input  logic               fwdFull,
  output logic               fwdPush,
  output logic [ENTRY_W-1:0] fwdData,
  input  logic [ADDR_W:0]    exitGray
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  fastStb_t          stb;
  logic [PTR_W-1:0]  exitS1, exitS2, exitBin, accCnt, inFlight;
  logic [3:0]        nEff;
  logic              room;
  entry_t            src, retEntry;

  // Exit count crossing from the slow domain.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      exitS1 <= '0; exitS2 <= '0; accCnt <= '0;
    end else begin
      exitS1 <= exitGray;
      exitS2 <= exitS1;
      if (stb.takeIn) accCnt <= accCnt + PTR_W'(1);
    end
  end

  always_comb begin
    exitBin[PTR_W-1] = exitS2[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) exitBin[i] = exitBin[i+1] ^ exitS2[i];
  end

  assign inFlight = accCnt - exitBin;
  assign room     = inFlight < PTR_W'(DEPTH);

  // Control: returning states win over new ones.
  assign stb.takeRet = !retEmpty && !fwdFull;
  assign stb.takeIn  = retEmpty && !fwdFull && room && inValid;
  assign inReady     = retEmpty && !fwdFull && room;
  assign retPop      = stb.takeRet;
  assign fwdPush     = stb.takeRet || stb.takeIn;

  // Datapath: constant addition and substitution.
  assign nEff     = (inRounds == 4'd0 || inRounds > 4'(MAX_ROUND)) ? 4'(MAX_ROUND) : inRounds;
  assign retEntry = entry_t'(retData);

  always_comb begin
    if (stb.takeRet) src = retEntry;
    else begin
      src.st  = inState;
      src.idx = RIDX_W'(MAX_ROUND) - nEff;
    end
    fwdData = {subLayer(src.st, src.idx), src.idx};
  end
endmodule

// File: rtl/ascon_slow_stage.sv
module ascon_slow_stage
  import ascon_split_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fwdEmpty,
  input  logic [ENTRY_W-1:0] fwdData,
  output logic               fwdPop,
  input  logic               retFull,
  output logic               retPush,
  output logic [ENTRY_W-1:0] retData,
  output logic               outValid,
  input  logic               outReady,
  output state_t             outState,
  output logic [ADDR_W:0]    exitGray
);
  localparam int PTR_W = ADDR_W + 1;

  slowStb_t         stb;
  entry_t           head;
  state_t           mixed;
  logic             isLast, outFree;
  logic [PTR_W-1:0] exitCnt, exitNext;

  assign head    = entry_t'(fwdData);
  assign isLast  = head.idx == LAST_IDX;
  assign outFree = !outValid || outReady;

  // Control: finished states go out, others return.
  assign stb.toOut = !fwdEmpty && isLast && outFree;
  assign stb.toRet = !fwdEmpty && !isLast && !retFull;
  assign fwdPop    = stb.toOut || stb.toRet;
  assign retPush   = stb.toRet;

  // Datapath: diffusion layer.
  assign mixed    = diffLayer(head.st);
  assign retData  = {mixed, head.idx + RIDX_W'(1)};
  assign exitNext = exitCnt + PTR_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outState <= '0;
      exitCnt  <= '0;
      exitGray <= '0;
    end else begin
      if (stb.toOut) begin
        outValid <= 1'b1;
        outState <= mixed;
      end else if (outReady) begin
        outValid <= 1'b0;
      end
      if (outValid && outReady) begin
        exitCnt  <= exitNext;
        exitGray <= exitNext ^ (exitNext >> 1);
      end
    end
  end
endmodule

// File: rtl/ascon_split_perm.sv
module ascon_split_perm
  import ascon_split_pkg::*;
#(
  parameter int FIFO_ADDR_W = 2
) (
  input  logic         clkFast,
  input  logic         rstFastN,
  input  logic         clkSlow,
  input  logic         rstSlowN,
  input  logic         inValid,
  output logic         inReady,
  input  logic [319:0] inState,
  input  logic [3:0]   inRounds,
  output logic         outValid,
  input  logic         outReady,
  output logic [319:0] outState
);
  logic                 fastRstN, slowRstN;
  logic                 fwdPush, fwdFull, fwdPop, fwdEmpty;
  logic                 retPush, retFull, retPop, retEmpty;
  logic [ENTRY_W-1:0]   fwdWData, fwdRData, retWData, retRData;
  logic [FIFO_ADDR_W:0] exitGray;

  ascon_rst_sync u_rstFast (.clk(clkFast), .arstN(rstFastN), .srstN(fastRstN));
  ascon_rst_sync u_rstSlow (.clk(clkSlow), .arstN(rstSlowN), .srstN(slowRstN));

  ascon_fast_stage #(.ADDR_W(FIFO_ADDR_W)) u_fast (
    .clk(clkFast), .rstN(fastRstN),
    .inValid(inValid), .inReady(inReady), .inState(inState), .inRounds(inRounds),
    .retEmpty(retEmpty), .retData(retRData), .retPop(retPop),
    .fwdFull(fwdFull), .fwdPush(fwdPush), .fwdData(fwdWData),
    .exitGray(exitGray)
  );

  ascon_xfifo #(.WIDTH(ENTRY_W), .ADDR_W(FIFO_ADDR_W)) u_fwdFifo (
    .wClk(clkFast), .wRstN(fastRstN), .wEn(fwdPush), .wData(fwdWData), .wFull(fwdFull),
    .rClk(clkSlow), .rRstN(slowRstN), .rEn(fwdPop), .rData(fwdRData), .rEmpty(fwdEmpty)
  );

  ascon_slow_stage #(.ADDR_W(FIFO_ADDR_W)) u_slow (
    .clk(clkSlow), .rstN(slowRstN),
    .fwdEmpty(fwdEmpty), .fwdData(fwdRData), .fwdPop(fwdPop),
    .retFull(retFull), .retPush(retPush), .retData(retWData),
    .outValid(outValid), .outReady(outReady), .outState(outState),
    .exitGray(exitGray)
  );

  ascon_xfifo #(.WIDTH(ENTRY_W), .ADDR_W(FIFO_ADDR_W)) u_retFifo (
    .wClk(clkSlow), .wRstN(slowRstN), .wEn(retPush), .wData(retWData), .wFull(retFull),
    .rClk(clkFast), .rRstN(fastRstN), .rEn(retPop), .rData(retRData), .rEmpty(retEmpty)
  );
endmodule

// File: rtl/ascon_split_chk.sv
module ascon_split_chk (
  input logic         clkFast,
  input logic         rstFastN,
  input logic         clkSlow,
  input logic         rstSlowN,
  input logic         outValid,
  input logic         outReady,
  input logic [319:0] outState,
  input logic         fwdPush,
  input logic         fwdFull,
  input logic         fwdPop,
  input logic         fwdEmpty,
  input logic         retPush,
  input logic         retFull,
  input logic         retPop,
  input logic         retEmpty
);
  assert_out_hold_R5: assert property (@(posedge clkSlow) disable iff (!rstSlowN)
    outValid && !outReady |=> outValid && $stable(outState));

  assert_no_overflow_R6: assert property (@(posedge clkFast) disable iff (!rstFastN)
    fwdPush |-> !fwdFull);

  assert_ret_overflow_R6: assert property (@(posedge clkSlow) disable iff (!rstSlowN)
    retPush |-> !retFull);

  assert_fwd_underflow_R9: assert property (@(posedge clkSlow) disable iff (!rstSlowN)
    fwdPop |-> !fwdEmpty);

  assert_ret_underflow_R9: assert property (@(posedge clkFast) disable iff (!rstFastN)
    retPop |-> !retEmpty);
endmodule

bind ascon_split_perm ascon_split_chk u_chk (
  .clkFast(clkFast), .rstFastN(rstFastN), .clkSlow(clkSlow), .rstSlowN(rstSlowN),
  .outValid(outValid), .outReady(outReady), .outState(outState),
  .fwdPush(fwdPush), .fwdFull(fwdFull), .fwdPop(fwdPop), .fwdEmpty(fwdEmpty),
  .retPush(retPush), .retFull(retFull), .retPop(retPop), .retEmpty(retEmpty)
);

// File: tb/sim_ascon_split_perm.sv
module sim_ascon_split_perm;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;

  logic         clkFast = 1'b0, clkSlow = 1'b0;
  logic         rstFastN = 1'b0, rstSlowN = 1'b0;
  logic         inValid = 1'b0, inReady;
  logic [319:0] inState = '0;
  logic [3:0]   inRounds = 4'd12;
  logic         outValid, outReady = 1'b1;
  logic [319:0] outState;

  int slowHalf = 10;
  int checks = 0, errors = 0, sentCount = 0;
  bit finished = 1'b0;
  logic [319:0] gotQ[$];

  ascon_split_perm u0 (
    .clkFast(clkFast), .rstFastN(rstFastN), .clkSlow(clkSlow), .rstSlowN(rstSlowN),
    .inValid(inValid), .inReady(inReady), .inState(inState), .inRounds(inRounds),
    .outValid(outValid), .outReady(outReady), .outState(outState)
  );

  always #(CLK_PERIOD/2) clkFast = ~clkFast;
  initial forever begin #(slowHalf); clkSlow = ~clkSlow; end

  always @(negedge clkSlow) begin
    #1;
    if (rstSlowN && outValid && outReady) gotQ.push_back(outState);
  end

  function automatic logic [63:0] ror(input logic [63:0] w, input int n);
    return (w >> n) | (w << (64 - n));
  endfunction

  function automatic logic [319:0] refPerm(input logic [319:0] s, input int n);
    logic [63:0] x[5];
    logic [63:0] t[5];
    logic [319:0] r;
    for (int w = 0; w < 5; w++) x[w] = s[319 - 64*w -: 64];
    for (int i = 12 - n; i < 12; i++) begin
      x[2] ^= 64'(((15 - i) << 4) | i);
      x[0] ^= x[4]; x[4] ^= x[3]; x[2] ^= x[1];
      for (int k = 0; k < 5; k++) t[k] = ~x[k] & x[(k + 1) % 5];
      for (int k = 0; k < 5; k++) x[k] ^= t[(k + 1) % 5];
      x[1] ^= x[0]; x[0] ^= x[4]; x[3] ^= x[2]; x[2] = ~x[2];
      x[0] = x[0] ^ ror(x[0], 19) ^ ror(x[0], 28);
      x[1] = x[1] ^ ror(x[1], 61) ^ ror(x[1], 39);
      x[2] = x[2] ^ ror(x[2], 1)  ^ ror(x[2], 6);
      x[3] = x[3] ^ ror(x[3], 10) ^ ror(x[3], 17);
      x[4] = x[4] ^ ror(x[4], 7)  ^ ror(x[4], 41);
    end
    for (int w = 0; w < 5; w++) r[319 - 64*w -: 64] = x[w];
    return r;
  endfunction

  function automatic logic [319:0] pattern(input int i);
    logic [63:0] b;
    b = 64'h0123456789abcdef ^ (64'(i + 1) * 64'h9e3779b97f4a7c15);
    return {b, ~b, {b[31:0], b[63:32]}, b ^ 64'h5a5a5a5a5a5a5a5a, 64'(i)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [319:0] act, input logic [319:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendOne(input logic [319:0] st, input logic [3:0] n);
    @(negedge clkFast);
    inValid = 1'b1; inState = st; inRounds = n;
    while (!inReady) @(negedge clkFast);
    @(negedge clkFast);
    inValid = 1'b0;
    sentCount++;
  endtask

  task automatic waitOut(input int n);
    int guard = 0;
    while (gotQ.size() < n && guard < 20000) begin
      @(negedge clkFast);
      guard++;
    end
  endtask

  task automatic testReset();
    repeat (6) @(negedge clkFast);
    chk(outValid == 1'b0, "R7 outValid after reset", 320'(outValid), 320'(0));
    chk(inReady == 1'b1, "R7 inReady after reset", 320'(inReady), 320'(1));
  endtask

  task automatic testOne(input logic [319:0] st, input logic [3:0] n, input int refN, input string tag);
    logic [319:0] exp;
    exp = refPerm(st, refN);
    gotQ.delete();
    sendOne(st, n);
    waitOut(1);
    repeat (4 * slowHalf) @(negedge clkFast);
    chk(gotQ.size() == 1, {tag, " output count"}, 320'(gotQ.size()), 320'(1));
    if (gotQ.size() >= 1) chk(gotQ[0] == exp, tag, gotQ[0], exp);
  endtask

  task automatic testRoundCounts();
    testOne('0, 4'd12, 12, "R1 zero state 12 rounds");
    testOne('1, 4'd12, 12, "R1 ones state 12 rounds");
    testOne(pattern(3), 4'd12, 12, "R1 pattern 12 rounds");
    testOne('0, 4'd1, 1, "R2 zero state 1 round");
    testOne(pattern(5), 4'd6, 6, "R2 pattern 6 rounds");
    testOne(pattern(7), 4'd11, 11, "R2 pattern 11 rounds");
    testOne(pattern(8), 4'd0, 12, "R3 count 0 as 12");
    testOne(pattern(9), 4'd13, 12, "R3 count 13 as 12");
    testOne(pattern(10), 4'd15, 12, "R3 count 15 as 12");
  endtask

  task automatic testBurst(input string tag, input int base);
    gotQ.delete();
    for (int i = 0; i < 6; i++) sendOne(pattern(base + i), 4'd12);
    waitOut(6);
    repeat (4 * slowHalf) @(negedge clkFast);
    chk(gotQ.size() == 6, {tag, " R9 burst count"}, 320'(gotQ.size()), 320'(6));
    for (int i = 0; i < 6 && i < gotQ.size(); i++)
      chk(gotQ[i] == refPerm(pattern(base + i), 12), {tag, " R4 burst order/value"},
          gotQ[i], refPerm(pattern(base + i), 12));
  endtask

  task automatic testBackpressure();
    logic [319:0] held;
    gotQ.delete();
    @(negedge clkSlow);
    outReady = 1'b0;
    sentCount = 0;
    fork
      begin
        for (int i = 0; i < 6; i++) sendOne(pattern(40 + i), 4'd12);
      end
    join_none
    repeat (3000) @(negedge clkFast);
    chk(sentCount == DEPTH, "R6 admission limit", 320'(sentCount), 320'(DEPTH));
    chk(inReady == 1'b0, "R6 inReady low when full", 320'(inReady), 320'(0));
    @(negedge clkSlow);
    held = outState;
    chk(outValid == 1'b1, "R5 outValid while stalled", 320'(outValid), 320'(1));
    repeat (20) @(negedge clkSlow);
    chk(outValid == 1'b1 && outState == held, "R5 outState held", outState, held);
    chk(gotQ.size() == 0, "R5 nothing delivered while stalled", 320'(gotQ.size()), 320'(0));
    outReady = 1'b1;
    waitOut(6);
    wait fork;
    repeat (4 * slowHalf) @(negedge clkFast);
    chk(gotQ.size() == 6, "R9 stalled burst count", 320'(gotQ.size()), 320'(6));
    for (int i = 0; i < 6 && i < gotQ.size(); i++)
      chk(gotQ[i] == refPerm(pattern(40 + i), 12), "R1 stalled burst value",
          gotQ[i], refPerm(pattern(40 + i), 12));
  endtask

  initial begin
    repeat (3) @(negedge clkFast);
    rstFastN = 1'b1;
    rstSlowN = 1'b1;
    testReset();
    testRoundCounts();
    testBurst("ratio2", 10);
    testBackpressure();
    slowHalf = 15;
    testBurst("R8 ratio3", 20);
    slowHalf = 5;
    testBurst("R8 ratio1", 30);
    slowHalf = 3;
    testBurst("R8 slow faster", 50);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule